// File: doc/BRIEF.md
# Privileged System Control Register Bank

This block holds the system control state of a 32-bit processor core: a mode/protection word, a fault-address word, a page-table root word and a feature word. The core's move-to/move-from path reaches them through one request port. Each request carries a 3-bit register number, a read/write flag and the current privilege level. An access that is not allowed does not complete. Instead it returns a fault code that the exception logic of the core acts on.

The memory management unit reports page faults on a separate input. The block stores the faulting linear address in the fault-address word without software help. A legal write to the page-table root raises a one-cycle flush request for the translation cache. The block drives the decoded enable bits on dedicated outputs every cycle, so the paging, caching and protection logic of the core can use them directly.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset all four implemented registers hold zero, so every enable output is 0. `rsp_valid`, `rsp_fault` and `tlb_flush` are also 0.
- R2: A request with `req_cpl` not equal to 0 returns fault code 1 (general protection) with read data 0, for any register number. No register changes. Privilege is checked before the register number.
- R3: At `req_cpl` 0, register numbers 1, 5, 6 and 7 return fault code 2 (undefined instruction) with read data 0, for both reads and writes. No register changes.
- R4: Register 0 stores the following bits:
  - bit 0: protected mode, on `en_protect`.
  - bit 16: supervisor write protection, on `en_wp`.
  - bit 29: not-write-through, on `en_no_wt`.
  - bit 30: cache disable, on `en_cache_dis`.
  - bit 31: paging, on `en_paging`.
  All other bits of register 0 read as zero.
- R5: A `pf_valid` pulse loads all 32 bits of `pf_addr` into register 2. A privileged write to register 2 also stores all 32 bits.
- R6: When a `pf_valid` pulse and a legal write to register 2 fall in the same cycle, register 2 takes `pf_addr`. The write still responds with fault code 0.
- R7: Register 3 stores the following, and all other bits read as zero:
  - bits 31:12: the table base, on `dir_base`.
  - bit 4: page-level cache disable, on `dir_pcd`.
  - bit 3: page-level write-through, on `dir_pwt`.
- R8: Each legal write to register 3 drives `tlb_flush` high for exactly the one cycle in which its response is valid. A read of register 3, or a faulted access, leaves `tlb_flush` low.
- R9: Register 4 stores the following:
  - bit 4: 4 MB pages, on `en_large_pg`.
  - bit 5: extended physical addressing, on `en_ext_phys`.
  - bit 7: global pages, on `en_global_pg`.
  A write that sets any other bit returns fault code 1 and leaves register 4 unchanged.
- R10: Every request produces `rsp_valid` exactly one cycle later, with its fault code on `rsp_fault` in the same cycle. The codes are 0 none, 1 general protection and 2 undefined instruction. Write responses return data 0. When `rsp_valid` is low, `rsp_fault` is 0.
- R11: A value written in one cycle is returned by a read issued in the next cycle, and it appears on the enable outputs from the cycle of the write's response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = move to register, 0 = move from register |
| req_idx | input | 3 | Register number |
| req_cpl | input | 2 | Current privilege level of the requester |
| req_wdata | input | 32 | Write data |
| pf_valid | input | 1 | Page fault reported by the MMU |
| pf_addr | input | 32 | Faulting linear address |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 on writes and faults) |
| rsp_fault | output | 2 | Fault code: 0 none, 1 general protection, 2 undefined |
| tlb_flush | output | 1 | One-cycle translation-cache flush request |
| en_protect | output | 1 | Protected mode enabled |
| en_wp | output | 1 | Supervisor write protection |
| en_no_wt | output | 1 | Not-write-through policy |
| en_cache_dis | output | 1 | Caching disabled |
| en_paging | output | 1 | Paging enabled |
| dir_base | output | 20 | Page-table root base, address bits 31:12 |
| dir_pcd | output | 1 | Page-level cache disable for the root |
| dir_pwt | output | 1 | Page-level write-through for the root |
| en_large_pg | output | 1 | 4 MB pages enabled |
| en_ext_phys | output | 1 | Extended physical addressing enabled |
| en_global_pg | output | 1 | Global pages enabled |

## Verification
The assertions check on every cycle that the fault code follows the privilege level, the reserved register numbers and the reserved feature bits. They also check that unprivileged accesses leave the state untouched, that a page-fault report always lands in register 2 (including when it collides with a write), that every flush traces back to a legal root write, and that responses are timed one cycle after their requests. The bench scenarios are needed for the rest: the bit masks on read-back, the mapping of each stored bit to its enable output, the reset contents, and write-then-read ordering over back-to-back requests.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned XLEN  = 32;
    localparam int unsigned IDX_W = 3;
    localparam int unsigned CPL_W = 2;
    localparam int unsigned NREGS = 1 << IDX_W;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_UD   = 2'd2
    } fault_e;

    localparam logic [IDX_W-1:0] IDX_MODE  = 3'd0;
    localparam logic [IDX_W-1:0] IDX_FADDR = 3'd2;
    localparam logic [IDX_W-1:0] IDX_ROOT  = 3'd3;
    localparam logic [IDX_W-1:0] IDX_FEAT  = 3'd4;

    // one bit per register number; set = number not implemented
    localparam logic [NREGS-1:0] RSVD_IDX_MAP = 8'b1110_0010;

    localparam logic [XLEN-1:0] MODE_MASK = 32'hE001_0001;
    localparam logic [XLEN-1:0] ROOT_MASK = 32'hFFFF_F018;
    localparam logic [XLEN-1:0] FEAT_MASK = 32'h0000_00B0;

    typedef struct packed {
        logic [XLEN-1:0] mode;
        logic [XLEN-1:0] faddr;
        logic [XLEN-1:0] root;
        logic [XLEN-1:0] feat;
    } ctl_regs_t;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] rdata;
        fault_e          fault;
        logic            flush;
    } ctl_rsp_t;

endpackage

// File: rtl/sysctl_access_check.sv
module sysctl_access_check
    import sysctl_pkg::*;
#(
    parameter int unsigned W     = XLEN,
    parameter int unsigned IW    = IDX_W,
    parameter int unsigned CW    = CPL_W
) (
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [IW-1:0] req_idx,
    input  logic [CW-1:0] req_cpl,
    input  logic [W-1:0]  req_wdata,
    output fault_e        fault,
    output logic          commit
);
    logic idx_rsvd;
    logic feat_bad;

    always_comb begin
        idx_rsvd = RSVD_IDX_MAP[req_idx];
        feat_bad = req_write && (req_idx == IDX_FEAT)
                   && ((req_wdata & ~FEAT_MASK) != '0);
        fault    = FLT_NONE;
        if (req_valid) begin
            if (req_cpl != '0) begin
                fault = FLT_GP;
            end else if (idx_rsvd) begin
                fault = FLT_UD;
            end else if (feat_bad) begin
                fault = FLT_GP;
            end
        end
        commit = req_valid && (fault == FLT_NONE);
    end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int unsigned W  = XLEN,
    parameter int unsigned IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic          pf_valid,
    input  logic [W-1:0]  pf_addr,
    output ctl_regs_t     regs
);
    ctl_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (wr_idx)
                IDX_MODE:  regs_d.mode  = wr_data & MODE_MASK;
                IDX_FADDR: regs_d.faddr = wr_data;
                IDX_ROOT:  regs_d.root  = wr_data & ROOT_MASK;
                IDX_FEAT:  regs_d.feat  = wr_data & FEAT_MASK;
                default:   regs_d = regs_q;
            endcase
        end
        // hardware capture takes precedence over a same-cycle write
        if (pf_valid) begin
            regs_d.faddr = pf_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs = regs_q;

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [2:0]       req_idx,
    input  logic [1:0]       req_cpl,
    input  logic [31:0]      req_wdata,
    input  logic             pf_valid,
    input  logic [31:0]      pf_addr,
    output logic             rsp_valid,
    output logic [31:0]      rsp_rdata,
    output logic [1:0]       rsp_fault,
    output logic             tlb_flush,
    output logic             en_protect,
    output logic             en_wp,
    output logic             en_no_wt,
    output logic             en_cache_dis,
    output logic             en_paging,
    output logic [19:0]      dir_base,
    output logic             dir_pcd,
    output logic             dir_pwt,
    output logic             en_large_pg,
    output logic             en_ext_phys,
    output logic             en_global_pg
);
    fault_e    chk_fault;
    logic      chk_commit;
    ctl_regs_t cr;
    logic [XLEN-1:0] cr_faddr;
    ctl_rsp_t  rsp_d, rsp_q;

    sysctl_access_check u_check (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_idx   (req_idx),
        .req_cpl   (req_cpl),
        .req_wdata (req_wdata),
        .fault     (chk_fault),
        .commit    (chk_commit)
    );

    sysctl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (chk_commit && req_write),
        .wr_idx   (req_idx),
        .wr_data  (req_wdata),
        .pf_valid (pf_valid),
        .pf_addr  (pf_addr),
        .regs     (cr)
    );

    assign cr_faddr = cr.faddr;

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        rsp_d.fault = chk_fault;
        rsp_d.flush = chk_commit && req_write && (req_idx == IDX_ROOT);
        if (chk_commit && !req_write) begin
            unique case (req_idx)
                IDX_MODE:  rsp_d.rdata = cr.mode;
                IDX_FADDR: rsp_d.rdata = cr.faddr;
                IDX_ROOT:  rsp_d.rdata = cr.root;
                IDX_FEAT:  rsp_d.rdata = cr.feat;
                default:   rsp_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_rdata    = rsp_q.rdata;
    assign rsp_fault    = rsp_q.fault;
    assign tlb_flush    = rsp_q.flush;

    assign en_protect   = cr.mode[0];
    assign en_wp        = cr.mode[16];
    assign en_no_wt     = cr.mode[29];
    assign en_cache_dis = cr.mode[30];
    assign en_paging    = cr.mode[31];
    assign dir_base     = cr.root[31:12];
    assign dir_pcd      = cr.root[4];
    assign dir_pwt      = cr.root[3];
    assign en_large_pg  = cr.feat[4];
    assign en_ext_phys  = cr.feat[5];
    assign en_global_pg = cr.feat[7];

endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk
    import sysctl_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [2:0]  req_idx,
    input logic [1:0]  req_cpl,
    input logic [31:0] req_wdata,
    input logic        pf_valid,
    input logic [31:0] pf_addr,
    input logic        rsp_valid,
    input logic [1:0]  rsp_fault,
    input logic        tlb_flush,
    input logic [31:0] faddr,
    input logic [19:0] dir_base,
    input logic        en_paging,
    input logic        en_protect,
    input logic        en_large_pg,
    input logic        en_ext_phys,
    input logic        en_global_pg
);
    assert_gp_user_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cpl != 2'd0) |=> (rsp_valid && rsp_fault == FLT_GP));

    assert_user_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cpl != 2'd0 && !pf_valid)
        |=> ($stable(faddr) && $stable(dir_base) && $stable(en_paging)
             && $stable(en_protect) && $stable(en_large_pg)));

    assert_ud_rsvd_idx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cpl == 2'd0 && (req_idx == 3'd1 || req_idx >= 3'd5))
        |=> (rsp_fault == FLT_UD));

    // also covers R6: capture wins over a same-cycle write
    assert_pf_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |=> (faddr == $past(pf_addr)));

    assert_flush_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush |-> $past(req_valid && req_write && req_idx == 3'd3 && req_cpl == 2'd0));

    assert_feat_rsvd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_cpl == 2'd0 && req_idx == 3'd4
         && (req_wdata & ~FEAT_MASK) != 32'd0)
        |=> (rsp_fault == FLT_GP && $stable(en_large_pg) && $stable(en_ext_phys)
             && $stable(en_global_pg)));

    assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_rsp_has_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    assert_idle_no_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_fault == FLT_NONE && !tlb_flush));

endmodule

bind sysctl_regbank sysctl_regbank_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_idx      (req_idx),
    .req_cpl      (req_cpl),
    .req_wdata    (req_wdata),
    .pf_valid     (pf_valid),
    .pf_addr      (pf_addr),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .tlb_flush    (tlb_flush),
    .faddr        (cr_faddr),
    .dir_base     (dir_base),
    .en_paging    (en_paging),
    .en_protect   (en_protect),
    .en_large_pg  (en_large_pg),
    .en_ext_phys  (en_ext_phys),
    .en_global_pg (en_global_pg)
);

// File: tb/sysctl_regbank_bench.sv
module sysctl_regbank_bench;

    typedef struct {
        logic [31:0] rdata;
        logic [1:0]  fault;
        logic        flush;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [2:0]  req_idx = '0;
    logic [1:0]  req_cpl = '0;
    logic [31:0] req_wdata = '0;
    logic        pf_valid = 1'b0;
    logic [31:0] pf_addr = '0;
    logic        rsp_valid, tlb_flush;
    logic [31:0] rsp_rdata;
    logic [1:0]  rsp_fault;
    logic        en_protect, en_wp, en_no_wt, en_cache_dis, en_paging;
    logic [19:0] dir_base;
    logic        dir_pcd, dir_pwt, en_large_pg, en_ext_phys, en_global_pg;

    int   n_checks = 0;
    int   n_fails  = 0;
    logic done     = 1'b0;
    exp_t sb[$];

    logic [31:0] m_mode = '0, m_faddr = '0, m_root = '0, m_feat = '0;

    always #2.5 clk = ~clk;

    sysctl_regbank u_sysctl_regbank (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_idx(req_idx),
        .req_cpl(req_cpl), .req_wdata(req_wdata),
        .pf_valid(pf_valid), .pf_addr(pf_addr),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
        .tlb_flush(tlb_flush),
        .en_protect(en_protect), .en_wp(en_wp), .en_no_wt(en_no_wt),
        .en_cache_dis(en_cache_dis), .en_paging(en_paging),
        .dir_base(dir_base), .dir_pcd(dir_pcd), .dir_pwt(dir_pwt),
        .en_large_pg(en_large_pg), .en_ext_phys(en_ext_phys),
        .en_global_pg(en_global_pg)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: computes the expected response from the requirements, then applies the request
    task automatic access(input logic wr, input logic [2:0] idx, input logic [1:0] cpl,
                          input logic [31:0] data, input logic pf, input logic [31:0] pfa,
                          input string tag);
        exp_t e;
        e.rdata = '0; e.fault = 2'd0; e.flush = 1'b0; e.tag = tag;
        if (cpl != 2'd0)                                   e.fault = 2'd1;
        else if (idx == 3'd1 || idx >= 3'd5)               e.fault = 2'd2;
        else if (wr && idx == 3'd4 && (data & ~32'hB0) != 0) e.fault = 2'd1;
        if (e.fault == 2'd0) begin
            if (wr) begin
                case (idx)
                    3'd0: m_mode  = data & 32'hE001_0001;
                    3'd2: m_faddr = data;
                    3'd3: begin m_root = data & 32'hFFFF_F018; e.flush = 1'b1; end
                    default: m_feat = data & 32'h0000_00B0;
                endcase
            end else begin
                case (idx)
                    3'd0: e.rdata = m_mode;
                    3'd2: e.rdata = m_faddr;
                    3'd3: e.rdata = m_root;
                    default: e.rdata = m_feat;
                endcase
            end
        end
        if (pf) m_faddr = pfa;
        sb.push_back(e);
        req_valid = 1'b1; req_write = wr; req_idx = idx; req_cpl = cpl;
        req_wdata = data; pf_valid = pf; pf_addr = pfa;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; pf_valid = 1'b0;
    endtask

    task automatic fault_report(input logic [31:0] a);
        m_faddr = a;
        pf_valid = 1'b1; pf_addr = a;
        @(negedge clk);
        pf_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expected items as responses appear
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    check(32'd1, 32'd0, "R10 response without request");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(rsp_rdata, e.rdata, {e.tag, " rdata"});
                    check({30'd0, rsp_fault}, {30'd0, e.fault}, {e.tag, " fault"});
                    check({31'd0, tlb_flush}, {31'd0, e.flush}, {e.tag, " R8 flush"});
                end
            end else begin
                check({29'd0, tlb_flush, rsp_fault}, 32'd0, "R10 idle outputs");
            end
        end
    end

    task automatic check_enables(input string tag);
        check({en_paging, en_cache_dis, en_no_wt, en_wp, en_protect},
              {m_mode[31], m_mode[30], m_mode[29], m_mode[16], m_mode[0]}, {tag, " R4 mode enables"});
        check({dir_base, dir_pcd, dir_pwt}, {m_root[31:12], m_root[4], m_root[3]}, {tag, " R7 root outputs"});
        check({en_global_pg, en_ext_phys, en_large_pg}, {m_feat[7], m_feat[5], m_feat[4]}, {tag, " R9 feature enables"});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({31'd0, rsp_valid}, 32'd0, "R1 rsp_valid");
        check_enables("R1 reset");
        access(1'b0, 3'd0, 2'd0, 0, 1'b0, 0, "R1 read reg0");
        access(1'b0, 3'd2, 2'd0, 0, 1'b0, 0, "R1 read reg2");
        access(1'b0, 3'd3, 2'd0, 0, 1'b0, 0, "R1 read reg3");
        access(1'b0, 3'd4, 2'd0, 0, 1'b0, 0, "R1 read reg4");
        // R4 / R11: masked write then back-to-back read
        access(1'b1, 3'd0, 2'd0, 32'hFFFF_FFFF, 1'b0, 0, "R4 write reg0");
        access(1'b0, 3'd0, 2'd0, 0, 1'b0, 0, "R11 read reg0 after write");
        idle(1); check_enables("R4 all set");
        access(1'b1, 3'd0, 2'd0, 32'h4001_0000, 1'b0, 0, "R4 write reg0 partial");
        idle(1); check_enables("R4 partial");
        // R7 / R8: root write with flush, read without flush
        access(1'b1, 3'd3, 2'd0, 32'hFFFF_FFFF, 1'b0, 0, "R7 write reg3");
        access(1'b0, 3'd3, 2'd0, 0, 1'b0, 0, "R7 read reg3 no flush");
        access(1'b1, 3'd3, 2'd0, 32'h1234_5008, 1'b0, 0, "R8 second reg3 write");
        access(1'b1, 3'd3, 2'd0, 32'hABCD_E010, 1'b0, 0, "R8 back-to-back reg3 write");
        idle(1); check_enables("R7 root");
        // R2: unprivileged accesses, privilege before index
        access(1'b1, 3'd3, 2'd3, 32'h0, 1'b0, 0, "R2 user write reg3");
        access(1'b1, 3'd0, 2'd1, 32'h0, 1'b0, 0, "R2 cpl1 write reg0");
        access(1'b0, 3'd2, 2'd2, 0, 1'b0, 0, "R2 cpl2 read reg2");
        access(1'b0, 3'd6, 2'd3, 0, 1'b0, 0, "R2 user reserved index");
        idle(1); check_enables("R2 unchanged");
        // R3: reserved indices
        for (int i = 0; i < 8; i++) begin
            if (i == 1 || i >= 5) begin
                access(1'b1, i[2:0], 2'd0, 32'hFFFF_FFFF, 1'b0, 0, "R3 reserved write");
                access(1'b0, i[2:0], 2'd0, 0, 1'b0, 0, "R3 reserved read");
            end
        end
        idle(1); check_enables("R3 unchanged");
        // R9: feature bits
        access(1'b1, 3'd4, 2'd0, 32'h0000_00B0, 1'b0, 0, "R9 legal feature write");
        access(1'b1, 3'd4, 2'd0, 32'h0000_0010, 1'b0, 0, "R9 large page only");
        access(1'b1, 3'd4, 2'd0, 32'h0000_00F0, 1'b0, 0, "R9 reserved bit 6 set");
        access(1'b1, 3'd4, 2'd0, 32'h8000_0000, 1'b0, 0, "R9 reserved bit 31 set");
        access(1'b0, 3'd4, 2'd0, 0, 1'b0, 0, "R9 read reg4 unchanged");
        idle(1); check_enables("R9 features");
        // R5 / R6: page fault capture
        fault_report(32'hDEAD_BEEF);
        access(1'b0, 3'd2, 2'd0, 0, 1'b0, 0, "R5 read captured address");
        access(1'b1, 3'd2, 2'd0, 32'h0BAD_F00D, 1'b0, 0, "R5 software write reg2");
        access(1'b0, 3'd2, 2'd0, 0, 1'b0, 0, "R5 read written reg2");
        access(1'b1, 3'd2, 2'd0, 32'h1111_1111, 1'b1, 32'hCAFE_0123, "R6 collision write");
        access(1'b0, 3'd2, 2'd0, 0, 1'b0, 0, "R6 capture wins");
        access(1'b1, 3'd3, 2'd1, 32'h0, 1'b1, 32'h7777_0000, "R2 user write with pf");
        access(1'b0, 3'd2, 2'd0, 0, 1'b0, 0, "R5 capture during faulted access");
        idle(3);
        check(sb.size(), 0, "R10 all responses seen");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule